// File: doc/BRIEF.md
# Interrupt Redirection Service Engine

This block sits between a set of interrupt lines and the processor-side message fabric. Each of its 24 pins owns a redirection entry: destination, destination mode, delivery mode, vector, trigger mode and a mask bit. A per-pin remote-pending flag is kept beside each entry and can only be changed by the engine. The engine keeps a pending bitmap. It scans the eligible pins from the lowest index upward and emits one delivery request at a time over a valid/ready handshake.

Edge pins are one-shot. A registered rising-edge detector sets their pending bit, and the bit clears when the request is issued. Level pins follow their line. Issuing a level request sets the pin's remote-pending flag. That flag blocks redelivery until an end-of-interrupt notification carrying the same vector arrives. For entries in external-interrupt delivery mode, the vector is taken from a side input fed by a legacy controller. Entries are loaded whole through a write port.

Top module: `irq_route_engine`

## Requirements
- R1: After reset no request is valid, every entry is masked with its remote-pending flag clear, and no pin is pending, so raising any line produces no request.
- R2: When several pins are eligible (pending, unmasked, and for level pins remote-pending clear), the lowest-numbered pin is issued first.
- R3: With trigger select 0 (edge), a rising line on an unmasked pin produces exactly one request, even if the line is held high. Its pending bit clears when the request is issued, and a new rise produces a new request.
- R4: A rising edge on a masked edge pin is discarded, so unmasking that pin later produces no request.
- R5: With trigger select 1 (level), the pending bit follows the line. Issuing the request sets the remote-pending flag, and no further request for that pin is made while the flag is set, even with the line still high.
- R6: An end-of-interrupt whose vector equals an entry's vector clears that entry's set remote-pending flag. If the line is still high and the entry is unmasked, the pin is delivered again. An end-of-interrupt with a different vector has no effect. If the line has dropped, clearing the flag produces no request.
- R7: Input line 0 drives pin 2, ORed with input line 2. Pin 0 has no input and never raises a request.
- R8: When the delivery mode field is 3'b111 (external interrupt), the request's vector is the ext_vec input sampled when the request is issued, not the entry's vector.
- R9: A request holds valid and all of its fields stable while req_ready is low. Only one request is outstanding at a time.
- R10: A masked level pin whose line is high is delivered once a write clears its mask. A write to an entry leaves its remote-pending flag unchanged.
- R11: Each request carries the entry's destination, destination mode, delivery mode, vector and trigger select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 24 | Interrupt input lines, active high |
| ext_vec | input | 8 | Vector from the legacy controller for external-interrupt entries |
| wr_en | input | 1 | Entry write strobe |
| wr_pin | input | 5 | Entry index to write; values above 23 are dropped |
| wr_vec | input | 8 | Vector field |
| wr_dlv | input | 3 | Delivery mode field, 3'b111 = external interrupt |
| wr_dstmode | input | 1 | Destination mode field |
| wr_trig | input | 1 | Trigger select, 0 = edge, 1 = level |
| wr_mask | input | 1 | Mask, 1 = masked |
| wr_dest | input | 8 | Destination field |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector of the end-of-interrupt |
| req_valid | output | 1 | Delivery request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_dest | output | 8 | Request destination |
| req_dstmode | output | 1 | Request destination mode |
| req_dlv | output | 3 | Request delivery mode |
| req_vec | output | 8 | Request vector |
| req_trig | output | 1 | Request trigger select |

## Verification
The bench targets the points where edge and level handling diverge. A line held high is the first such point: an engine without the edge detector would flood edge requests, and one without the remote flag would flood level requests. The end-of-interrupt cases use a wrong vector, a line still high, and a line already low. A design that ignores the vector match, or does not recheck the line, would emit a request where none is due, or miss one. The bench also covers a masked edge rise followed by an unmask, which a design that latches masked edges would deliver late. Further cases are line 0 landing on pin 2, simultaneous pins with mixed masks, an external-interrupt vector, and a stalled handshake whose fields must not move.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DLV_W  = 3;
  localparam logic [DLV_W-1:0] DLV_EXTINT = 3'b111;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig;     // 1 = level
    logic              dstmode;
    logic [DLV_W-1:0]  dlv;
    logic [VEC_W-1:0]  vec;
  } rte_t;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              dstmode;
    logic [DLV_W-1:0]  dlv;
    logic [VEC_W-1:0]  vec;
    logic              trig;
  } dreq_t;
endpackage

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int W     = 24,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [W-1:0]     grant
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = i[IDX_W-1:0];
      end
    end
    grant = '0;
    if (found) grant[idx] = 1'b1;
  end
endmodule

// File: rtl/irq_entry_table.sv
module irq_entry_table
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PIN_W-1:0]         wr_pin,
  input  rte_t                     wr_entry,
  input  logic                     eoi_valid,
  input  logic [VEC_W-1:0]         eoi_vec,
  input  logic [NUM_PINS-1:0]      rset,
  output rte_t [NUM_PINS-1:0]      ent_o,
  output logic [NUM_PINS-1:0]      rem_o
);
  localparam rte_t RST_ENT = '{dest: '0, mask: 1'b1, trig: 1'b0,
                               dstmode: 1'b0, dlv: '0, vec: '0};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    localparam logic [PIN_W-1:0] MY_PIN = PIN_W'(g);
    rte_t ent_q, ent_d;
    logic rem_q, rem_d;
    logic wr_hit, eoi_hit;

    assign wr_hit  = wr_en && (wr_pin == MY_PIN);
    assign eoi_hit = eoi_valid && rem_q && (ent_q.vec == eoi_vec);

    always_comb begin
      ent_d = wr_hit ? wr_entry : ent_q;
      rem_d = rem_q;
      if (eoi_hit)  rem_d = 1'b0;
      if (rset[g])  rem_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= RST_ENT;
        rem_q <= 1'b0;
      end else begin
        ent_q <= ent_d;
        rem_q <= rem_d;
      end
    end

    assign ent_o[g] = ent_q;
    assign rem_o[g] = rem_q;

    // R6: a matching end-of-interrupt clears a set remote-pending flag
    a_r6_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && rem_q && ent_q.vec == eoi_vec) |=> !rem_q);
  end
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = $clog2(NUM_PINS),
  parameter int ALIAS_IN = 0,
  parameter int ALIAS_PIN = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [VEC_W-1:0]    ext_vec,
  input  logic                wr_en,
  input  logic [PIN_W-1:0]    wr_pin,
  input  logic [VEC_W-1:0]    wr_vec,
  input  logic [DLV_W-1:0]    wr_dlv,
  input  logic                wr_dstmode,
  input  logic                wr_trig,
  input  logic                wr_mask,
  input  logic [DEST_W-1:0]   wr_dest,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vec,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [DEST_W-1:0]   req_dest,
  output logic                req_dstmode,
  output logic [DLV_W-1:0]    req_dlv,
  output logic [VEC_W-1:0]    req_vec,
  output logic                req_trig
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // line-to-pin mapping
  logic [NUM_PINS-1:0] pin_lvl;
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_map
    if (g == ALIAS_IN) begin : g_none
      assign pin_lvl[g] = 1'b0;
    end else if (g == ALIAS_PIN) begin : g_alias
      assign pin_lvl[g] = irq_in[g] | irq_in[ALIAS_IN];
    end else begin : g_direct
      assign pin_lvl[g] = irq_in[g];
    end
  end

  logic [NUM_PINS-1:0] rise;
  irq_rise_det #(.W(NUM_PINS)) i_rise (
    .clk(clk), .rst_n(rst_int_n), .lvl(pin_lvl), .rise(rise)
  );

  // entry table
  rte_t                wr_entry;
  rte_t [NUM_PINS-1:0] ent;
  logic [NUM_PINS-1:0] rem;
  logic [NUM_PINS-1:0] rset;

  assign wr_entry = '{dest: wr_dest, mask: wr_mask, trig: wr_trig,
                      dstmode: wr_dstmode, dlv: wr_dlv, vec: wr_vec};

  irq_entry_table #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) i_table (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(wr_en), .wr_pin(wr_pin), .wr_entry(wr_entry),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .rset(rset), .ent_o(ent), .rem_o(rem)
  );

  // eligibility and pick
  logic [NUM_PINS-1:0] pend_q, pend_d, elig, grant;
  logic                found, load;
  logic [PIN_W-1:0]    pick_idx;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_elig
    assign elig[g] = pend_q[g] && !ent[g].mask && (!ent[g].trig || !rem[g]);
  end

  irq_lowest_pick #(.W(NUM_PINS), .IDX_W(PIN_W)) i_pick (
    .req(elig), .found(found), .idx(pick_idx), .grant(grant)
  );

  logic req_valid_q, req_valid_d;
  dreq_t pay_q, pay_d;
  rte_t sel;

  assign load = !req_valid_q && found;
  assign sel  = ent[pick_idx];

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (ent[i].trig) begin
        pend_d[i] = pin_lvl[i];
        rset[i]   = load && grant[i];
      end else begin
        pend_d[i] = (pend_q[i] && !(load && grant[i])) || (rise[i] && !ent[i].mask);
        rset[i]   = 1'b0;
      end
    end
  end

  always_comb begin
    req_valid_d = req_valid_q && !req_ready;
    pay_d       = pay_q;
    if (load) begin
      req_valid_d   = 1'b1;
      pay_d.dest    = sel.dest;
      pay_d.dstmode = sel.dstmode;
      pay_d.dlv     = sel.dlv;
      pay_d.vec     = (sel.dlv == DLV_EXTINT) ? ext_vec : sel.vec;
      pay_d.trig    = sel.trig;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q      <= '0;
      req_valid_q <= 1'b0;
      pay_q       <= '0;
    end else begin
      pend_q      <= pend_d;
      req_valid_q <= req_valid_d;
      if (load) pay_q <= pay_d;
    end
  end

  assign req_valid   = req_valid_q;
  assign req_dest    = pay_q.dest;
  assign req_dstmode = pay_q.dstmode;
  assign req_dlv     = pay_q.dlv;
  assign req_vec     = pay_q.vec;
  assign req_trig    = pay_q.trig;

  // R2: at most one pin granted per pick
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(grant));

  // R9: a stalled request keeps valid and its fields
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(pay_q)));

  // R5: issuing a level pin leaves its remote-pending flag set
  a_r5_remote_set: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load && sel.trig) |=> rem[$past(pick_idx)]);

  // R3: issuing an edge pin with no fresh rise clears its pending bit
  a_r3_edge_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load && !sel.trig && !rise[pick_idx]) |=> !pend_q[$past(pick_idx)]);
endmodule

// File: tb/test_irq_route_engine.sv
module test_irq_route_engine;
  localparam int NP = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NP-1:0] irq_in;
  logic [7:0]  ext_vec;
  logic        wr_en;
  logic [4:0]  wr_pin;
  logic [7:0]  wr_vec;
  logic [2:0]  wr_dlv;
  logic        wr_dstmode, wr_trig, wr_mask;
  logic [7:0]  wr_dest;
  logic        eoi_valid;
  logic [7:0]  eoi_vec;
  logic        req_valid, req_ready;
  logic [7:0]  req_dest;
  logic        req_dstmode;
  logic [2:0]  req_dlv;
  logic [7:0]  req_vec;
  logic        req_trig;

  always #5 clk = ~clk;

  irq_route_engine i_irq_route_engine (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ext_vec(ext_vec),
    .wr_en(wr_en), .wr_pin(wr_pin), .wr_vec(wr_vec), .wr_dlv(wr_dlv),
    .wr_dstmode(wr_dstmode), .wr_trig(wr_trig), .wr_mask(wr_mask),
    .wr_dest(wr_dest), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .req_valid(req_valid), .req_ready(req_ready), .req_dest(req_dest),
    .req_dstmode(req_dstmode), .req_dlv(req_dlv), .req_vec(req_vec),
    .req_trig(req_trig)
  );

  typedef struct {
    logic [7:0] vec;
    logic [2:0] dlv;
    logic       dm;
    logic [7:0] dest;
    logic       trig;
    string      tag;
  } exp_t;

  exp_t  sbq[$];
  int    checks = 0;
  int    fails  = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  logic [7:0] sh_vec [NP];
  logic [2:0] sh_dlv [NP];
  logic       sh_dm  [NP];
  logic [7:0] sh_dest[NP];
  logic       sh_trig[NP];

  // monitor: pops one expected item per accepted request
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && req_valid && req_ready && !done) begin
      checks++;
      if (sbq.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected request vec=%h, expected none", cur_tag, req_vec);
      end else begin
        e = sbq.pop_front();
        if (req_vec !== e.vec || req_dlv !== e.dlv || req_dstmode !== e.dm ||
            req_dest !== e.dest || req_trig !== e.trig) begin
          fails++;
          $display("FAIL %s: got vec=%h dlv=%0d dm=%0b dest=%h trig=%0b, expected vec=%h dlv=%0d dm=%0b dest=%h trig=%0b",
                   e.tag, req_vec, req_dlv, req_dstmode, req_dest, req_trig,
                   e.vec, e.dlv, e.dm, e.dest, e.trig);
        end
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
      $finish;
    end
  end

  task automatic write_ent(int pin, logic [7:0] vec, logic [2:0] dlv, logic dm,
                           logic trig, logic mask, logic [7:0] dest);
    @(negedge clk);
    wr_en = 1'b1; wr_pin = pin[4:0]; wr_vec = vec; wr_dlv = dlv;
    wr_dstmode = dm; wr_trig = trig; wr_mask = mask; wr_dest = dest;
    @(negedge clk);
    wr_en = 1'b0;
    sh_vec[pin] = vec; sh_dlv[pin] = dlv; sh_dm[pin] = dm;
    sh_dest[pin] = dest; sh_trig[pin] = trig;
  endtask

  task automatic expect_pin(int pin, string tag);
    exp_t e;
    e.vec = sh_vec[pin]; e.dlv = sh_dlv[pin]; e.dm = sh_dm[pin];
    e.dest = sh_dest[pin]; e.trig = sh_trig[pin]; e.tag = tag;
    if (sh_dlv[pin] == 3'b111) e.vec = ext_vec;
    sbq.push_back(e);
  endtask

  task automatic drain(string tag, int n);
    repeat (n) @(negedge clk);
    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected requests missing, expected 0", tag, sbq.size());
      sbq.delete();
    end
  endtask

  task automatic set_line(int pin, logic v);
    @(negedge clk);
    irq_in[pin] = v;
  endtask

  task automatic eoi(logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vec = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; ext_vec = 8'h00; wr_en = 1'b0; wr_pin = '0;
    wr_vec = '0; wr_dlv = '0; wr_dstmode = 1'b0; wr_trig = 1'b0; wr_mask = 1'b1;
    wr_dest = '0; eoi_valid = 1'b0; eoi_vec = '0; req_ready = 1'b1;
    for (int i = 0; i < NP; i++) begin
      sh_vec[i] = '0; sh_dlv[i] = '0; sh_dm[i] = 1'b0; sh_dest[i] = '0; sh_trig[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle after reset, default masks block a raised line
    cur_tag = "R1";
    checks++;
    if (req_valid !== 1'b0) begin
      fails++; $display("FAIL R1: req_valid=%b, expected 0", req_valid);
    end
    set_line(5, 1'b1); set_line(9, 1'b1);
    drain("R1", 10);
    set_line(5, 1'b0); set_line(9, 1'b0);

    // R3 / R11: edge pin, held high gives one request, new rise gives another
    cur_tag = "R3";
    write_ent(5, 8'h35, 3'd1, 1'b1, 1'b0, 1'b0, 8'hA5);
    expect_pin(5, "R11");
    set_line(5, 1'b1);
    drain("R3", 12);
    set_line(5, 1'b0);
    expect_pin(5, "R3");
    set_line(5, 1'b1);
    drain("R3", 8);
    set_line(5, 1'b0);

    // R4: masked edge rise is discarded
    cur_tag = "R4";
    write_ent(6, 8'h36, 3'd0, 1'b0, 1'b0, 1'b1, 8'h06);
    set_line(6, 1'b1);
    repeat (4) @(negedge clk);
    write_ent(6, 8'h36, 3'd0, 1'b0, 1'b0, 1'b0, 8'h06);
    drain("R4", 10);
    set_line(6, 1'b0);

    // R5 / R6: level pin, remote flag, end-of-interrupt handling
    cur_tag = "R5";
    write_ent(9, 8'h49, 3'd2, 1'b0, 1'b1, 1'b0, 8'h19);
    expect_pin(9, "R5");
    set_line(9, 1'b1);
    drain("R5", 12);
    cur_tag = "R6";
    eoi(8'h48);
    drain("R6", 8);
    expect_pin(9, "R6");
    eoi(8'h49);
    drain("R6", 8);
    set_line(9, 1'b0);
    eoi(8'h49);
    drain("R6", 8);
    expect_pin(9, "R6");
    set_line(9, 1'b1);
    drain("R6", 8);
    set_line(9, 1'b0);
    eoi(8'h49);

    // R2: simultaneous pins, lowest index first, masked one skipped
    cur_tag = "R2";
    write_ent(10, 8'h5A, 3'd0, 1'b0, 1'b0, 1'b0, 8'h0A);
    write_ent(11, 8'h5B, 3'd0, 1'b0, 1'b0, 1'b1, 8'h0B);
    write_ent(12, 8'h5C, 3'd0, 1'b1, 1'b0, 1'b0, 8'h0C);
    expect_pin(10, "R2");
    expect_pin(12, "R2");
    @(negedge clk);
    irq_in[10] = 1'b1; irq_in[11] = 1'b1; irq_in[12] = 1'b1;
    drain("R2", 12);
    @(negedge clk);
    irq_in[10] = 1'b0; irq_in[11] = 1'b0; irq_in[12] = 1'b0;

    // R7: line 0 lands on pin 2, pin 0 stays silent
    cur_tag = "R7";
    write_ent(0, 8'h20, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00);
    write_ent(2, 8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 8'h02);
    expect_pin(2, "R7");
    set_line(0, 1'b1);
    drain("R7", 10);
    set_line(0, 1'b0);

    // R8: external-interrupt vector comes from ext_vec
    cur_tag = "R8";
    ext_vec = 8'hC3;
    write_ent(14, 8'h77, 3'b111, 1'b0, 1'b0, 1'b0, 8'h0E);
    expect_pin(14, "R8");
    set_line(14, 1'b1);
    drain("R8", 10);
    set_line(14, 1'b0);

    // R9: stalled handshake holds fields
    cur_tag = "R9";
    write_ent(15, 8'h6F, 3'd0, 1'b1, 1'b0, 1'b0, 8'h1F);
    write_ent(16, 8'h70, 3'd0, 1'b0, 1'b0, 1'b0, 8'h20);
    @(posedge clk); #1 req_ready = 1'b0;
    expect_pin(15, "R9");
    expect_pin(16, "R9");
    @(negedge clk);
    irq_in[15] = 1'b1; irq_in[16] = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      checks++;
      if (req_valid !== 1'b1 || req_vec !== 8'h6F || req_dest !== 8'h1F) begin
        fails++;
        $display("FAIL R9: valid=%b vec=%h dest=%h, expected 1 6f 1f", req_valid, req_vec, req_dest);
      end
    end
    @(posedge clk); #1 req_ready = 1'b1;
    drain("R9", 10);
    @(negedge clk);
    irq_in[15] = 1'b0; irq_in[16] = 1'b0;

    // R10: unmasking a high level pin delivers it; rewrite keeps remote flag
    cur_tag = "R10";
    write_ent(18, 8'h82, 3'd0, 1'b0, 1'b1, 1'b1, 8'h12);
    set_line(18, 1'b1);
    drain("R10", 8);
    expect_pin(18, "R10");
    write_ent(18, 8'h82, 3'd0, 1'b0, 1'b1, 1'b0, 8'h12);
    drain("R10", 8);
    write_ent(18, 8'h82, 3'd0, 1'b0, 1'b1, 1'b0, 8'h12);
    drain("R10", 8);
    expect_pin(18, "R10");
    eoi(8'h82);
    drain("R10", 8);
    set_line(18, 1'b0);
    eoi(8'h82);
    drain("R10", 6);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule